// File: doc/BRIEF.md
# SCSI host DMA channel registers

This block holds the register state and the per-beat bookkeeping of a bus-master DMA channel inside a SCSI host adapter. Software programs a starting byte count, a starting memory address and a starting descriptor address, then writes a command. A start command copies the starting values into working registers and enables the DMA request toward the SCSI engine. An idle command withdraws that request. An abort command sends a one-cycle cancel pulse to the SCSI engine. A blast command has no effect.

While the channel runs, the host bus master offers transfer beats on a valid/ready interface. Each beat states a length and a direction. The block answers each beat in the same cycle with the number of bytes that may move, or with a reject if the direction disagrees with the command. It then steps the working count down and the working address up. A done flag is raised when the count reaches zero, or when the SCSI engine reports that its command has completed.

The status register can be cleared in one of two ways, and a bit in a separate bus-control register selects which. In one mode a read clears the error, abort and done bits. In the other, a write of ones clears them. The SCSI engine's interrupt line is merged into every status read but is never stored.

Top module: `hdma_channel`

## Requirements
- R1: After reset:
  - the command register, bus-control register and status bits [5:0] read 0;
  - the working count reads 0;
  - the working address reads all ones, and the working descriptor address reads all ones except bit 1 (0x...FFFD);
  - `dma_req_en`, `scsi_cancel` and `dma_done` are 0.
- R2: Command bits [7:0] are stored and read back. Bits [1:0] select the operation: 0 idle, 1 blast, 2 abort, 3 start. Bit 7 gives the expected direction, with 1 meaning device to memory. An idle write drops `dma_req_en`, a start write raises it, and a blast write changes nothing else.
- R3: A start write loads the working count from the starting count, the working address from the starting address and the working descriptor address from the starting descriptor address. It also clears status bits [5:0]. All of these take effect on the next clock edge.
- R4: An abort write makes `scsi_cancel` high for exactly the following cycle. It leaves the working count, working address and `dma_req_en` unchanged.
- R5: An accepted beat with matching direction reports `xfer_moved` = min(`xfer_len`, working count) in the same cycle. At the next edge the working count decreases by that amount and the working address increases by it.
- R6: When an accepted beat brings the working count to zero, status bit 3 (done) and `dma_done` are set.
- R7: A beat whose `xfer_to_mem` differs from command bit 7 asserts `xfer_reject`, reports `xfer_moved` = 0, and changes no register.
- R8: A read of the status register shows bit 4 = `scsi_irq`. That bit is not stored.
- R9: With bus-control bit 24 clear, a status read returns the current value and then clears bits 1 (error), 2 (abort) and 3 (done). In this mode a status write has no effect.
- R10: With bus-control bit 24 set, a status write clears each of bits 1, 2 and 3 that is written as 1. In this mode a status read clears nothing.
- R11: A `scsi_cmd_done` pulse forces the working count to 0 and sets done, unless a start write falls in the same cycle; in that case the start wins.
- R12: `xfer_ready` is low in any cycle with a command-register write or a `scsi_cmd_done` pulse. A beat offered in such a cycle is not taken and updates nothing.
- R13: The register word indices are:
  - 0: command
  - 1: starting count
  - 2: starting address
  - 3: starting descriptor address
  - 4: working count (read only)
  - 5: working address (read only)
  - 6: status
  - 7: working descriptor address (read only)
  - 8: bus control

  Other indices read 0. Writes to read-only or unused indices are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (drives clear-on-read) |
| reg_addr | input | RAW | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| scsi_irq | input | 1 | SCSI engine interrupt flag |
| scsi_cmd_done | input | 1 | SCSI command completion pulse |
| xfer_valid | input | 1 | Transfer beat offered |
| xfer_ready | output | 1 | Beat can be taken this cycle |
| xfer_to_mem | input | 1 | Beat direction, 1 = device to memory |
| xfer_len | input | LEN_W | Requested byte count of the beat |
| xfer_moved | output | LEN_W | Bytes granted for the beat |
| xfer_reject | output | 1 | Direction mismatch, beat moves nothing |
| dma_req_en | output | 1 | DMA request enable toward the SCSI engine |
| scsi_cancel | output | 1 | One-cycle cancel pulse after an abort |
| dma_done | output | 1 | Stored done status bit |

## Verification
The bench builds the channel with COUNT_W=8, LEN_W=4 and ADDR_W=16. With these widths, every starting count from 0 to 31 can be swept against every beat length from 0 to 15. That sweep covers both branches of the length/count minimum, the exact-equal case and the zero-count case, and each expected result is computed arithmetically. The 16-bit address keeps the all-ones reset values short enough to check directly. Directed sequences then cover both status-clear modes, the merged interrupt bit, completion, abort and back-pressure.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } hdma_op_e;

  localparam int CMD_W   = 8;
  localparam int CB_DIR  = 7;
  localparam int ST_W    = 6;
  localparam int ST_ERR  = 1;
  localparam int ST_ABT  = 2;
  localparam int ST_DONE = 3;
  localparam int ST_SINT = 4;
  localparam int BC_WCLR = 24;

  localparam int RI_CMD   = 0;
  localparam int RI_SCNT  = 1;
  localparam int RI_SADR  = 2;
  localparam int RI_SDSC  = 3;
  localparam int RI_WCNT  = 4;
  localparam int RI_WADR  = 5;
  localparam int RI_STAT  = 6;
  localparam int RI_WDSC  = 7;
  localparam int RI_BCTL  = 8;
endpackage

// File: rtl/hdma_cmd_dec.sv
module hdma_cmd_dec
  import hdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic [CMD_W-1:0] wdata,
  output logic [CMD_W-1:0] cmd_q,
  output logic             start_p,
  output logic             dma_en_q,
  output logic             cancel_q
);
  hdma_op_e op;
  assign op      = hdma_op_e'(wdata[1:0]);
  assign start_p = wr_cmd && (op == OP_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      dma_en_q <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      cancel_q <= wr_cmd && (op == OP_ABORT);
      if (wr_cmd) begin
        cmd_q <= wdata;
        if (op == OP_START)     dma_en_q <= 1'b1;
        else if (op == OP_IDLE) dma_en_q <= 1'b0;
      end
    end
  end

  // R2
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata[1:0] == 2'd0) |=> !dma_en_q);
endmodule

// File: rtl/hdma_xfer_calc.sv
module hdma_xfer_calc #(
  parameter int COUNT_W = 16,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 12
) (
  input  logic [COUNT_W-1:0] wbc,
  input  logic [ADDR_W-1:0]  wac,
  input  logic [LEN_W-1:0]   len,
  input  logic               dir_req,
  input  logic               dir_cmd,
  output logic               reject,
  output logic [LEN_W-1:0]   moved_len,
  output logic [COUNT_W-1:0] moved_cnt,
  output logic [COUNT_W-1:0] wbc_next,
  output logic [ADDR_W-1:0]  wac_next,
  output logic               hits_zero
);
  logic [COUNT_W-1:0] len_ext;
  logic               take_len;

  assign len_ext   = COUNT_W'(len);
  assign take_len  = (len_ext <= wbc);
  assign reject    = (dir_req != dir_cmd);
  assign moved_cnt = reject ? '0 : (take_len ? len_ext : wbc);
  assign moved_len = reject ? '0 : (take_len ? len : wbc[LEN_W-1:0]);
  assign wbc_next  = wbc - moved_cnt;
  assign wac_next  = wac + ADDR_W'(moved_cnt);
  assign hits_zero = (wbc_next == '0);
endmodule

// File: rtl/hdma_status.sv
module hdma_status
  import hdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_all,
  input  logic            set_done,
  input  logic            rd_stat,
  input  logic            wr_stat,
  input  logic            wclr_mode,
  input  logic [ST_W-1:0] wdata,
  output logic [ST_W-1:0] stat_q
);
  localparam logic [ST_W-1:0] CLR_MASK =
    ST_W'((1 << ST_ERR) | (1 << ST_ABT) | (1 << ST_DONE));

  logic [ST_W-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (rd_stat && !wclr_mode) stat_d = stat_d & ~CLR_MASK;
    if (wr_stat && wclr_mode)  stat_d = stat_d & ~(wdata & CLR_MASK);
    if (set_done)              stat_d[ST_DONE] = 1'b1;
    if (clr_all)               stat_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !wclr_mode && !set_done && !clr_all) |=> (stat_q[3:1] == 3'b000));
  // R10
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wclr_mode && wdata[3] && !set_done) |=> !stat_q[3]);
endmodule

// File: rtl/hdma_channel.sv
module hdma_channel
  import hdma_pkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 12,
  parameter int RAW     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             scsi_irq,
  input  logic             scsi_cmd_done,
  input  logic             xfer_valid,
  output logic             xfer_ready,
  input  logic             xfer_to_mem,
  input  logic [LEN_W-1:0] xfer_len,
  output logic [LEN_W-1:0] xfer_moved,
  output logic             xfer_reject,
  output logic             dma_req_en,
  output logic             scsi_cancel,
  output logic             dma_done
);
  localparam logic [ADDR_W-1:0] WAC_RST = '1;
  localparam logic [ADDR_W-1:0] WDSC_RST = ~(ADDR_W'(2));

  logic [COUNT_W-1:0] start_cnt_q, wbc_q, moved_cnt, wbc_next;
  logic [ADDR_W-1:0]  start_adr_q, start_dsc_q, wac_q, wdsc_q, wac_next;
  logic [31:0]        bctl_q;
  logic [CMD_W-1:0]   cmd_q;
  logic [ST_W-1:0]    stat_q, stat_view;
  logic               start_p, reject, hits_zero;
  logic               wr_cmd, fire, beat_ok, set_done;

  function automatic logic hit(input logic [RAW-1:0] a, input int idx);
    return a == RAW'(idx);
  endfunction

  assign wr_cmd = reg_wr_en && hit(reg_addr, RI_CMD);

  hdma_cmd_dec u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(reg_wdata[CMD_W-1:0]),
    .cmd_q(cmd_q), .start_p(start_p), .dma_en_q(dma_req_en), .cancel_q(scsi_cancel)
  );

  hdma_xfer_calc #(.COUNT_W(COUNT_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_calc (
    .wbc(wbc_q), .wac(wac_q), .len(xfer_len), .dir_req(xfer_to_mem),
    .dir_cmd(cmd_q[CB_DIR]), .reject(reject), .moved_len(xfer_moved),
    .moved_cnt(moved_cnt), .wbc_next(wbc_next), .wac_next(wac_next),
    .hits_zero(hits_zero)
  );

  assign xfer_ready  = !wr_cmd && !scsi_cmd_done;
  assign xfer_reject = reject;
  assign fire        = xfer_valid && xfer_ready;
  assign beat_ok     = fire && !reject;
  assign set_done    = scsi_cmd_done || (beat_ok && hits_zero);

  hdma_status u_stat (
    .clk(clk), .rst_n(rst_n), .clr_all(start_p), .set_done(set_done),
    .rd_stat(reg_rd_en && hit(reg_addr, RI_STAT)),
    .wr_stat(reg_wr_en && hit(reg_addr, RI_STAT)),
    .wclr_mode(bctl_q[BC_WCLR]), .wdata(reg_wdata[ST_W-1:0]), .stat_q(stat_q)
  );
  assign dma_done = stat_q[ST_DONE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_cnt_q <= '0;
      start_adr_q <= '0;
      start_dsc_q <= '0;
      bctl_q      <= '0;
    end else if (reg_wr_en) begin
      if (hit(reg_addr, RI_SCNT)) start_cnt_q <= reg_wdata[COUNT_W-1:0];
      if (hit(reg_addr, RI_SADR)) start_adr_q <= reg_wdata[ADDR_W-1:0];
      if (hit(reg_addr, RI_SDSC)) start_dsc_q <= reg_wdata[ADDR_W-1:0];
      if (hit(reg_addr, RI_BCTL)) bctl_q      <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbc_q  <= '0;
      wac_q  <= WAC_RST;
      wdsc_q <= WDSC_RST;
    end else if (start_p) begin
      wbc_q  <= start_cnt_q;
      wac_q  <= start_adr_q;
      wdsc_q <= start_dsc_q;
    end else if (scsi_cmd_done) begin
      wbc_q  <= '0;
    end else if (beat_ok) begin
      wbc_q  <= wbc_next;
      wac_q  <= wac_next;
    end
  end

  always_comb begin
    stat_view          = stat_q;
    stat_view[ST_SINT] = stat_q[ST_SINT] | scsi_irq;
  end

  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, RI_CMD))  reg_rdata = 32'(cmd_q);
    if (hit(reg_addr, RI_SCNT)) reg_rdata = 32'(start_cnt_q);
    if (hit(reg_addr, RI_SADR)) reg_rdata = 32'(start_adr_q);
    if (hit(reg_addr, RI_SDSC)) reg_rdata = 32'(start_dsc_q);
    if (hit(reg_addr, RI_WCNT)) reg_rdata = 32'(wbc_q);
    if (hit(reg_addr, RI_WADR)) reg_rdata = 32'(wac_q);
    if (hit(reg_addr, RI_STAT)) reg_rdata = 32'(stat_view);
    if (hit(reg_addr, RI_WDSC)) reg_rdata = 32'(wdsc_q);
    if (hit(reg_addr, RI_BCTL)) reg_rdata = bctl_q;
  end

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (wbc_q == $past(start_cnt_q)) && (wac_q == $past(start_adr_q))
                && (stat_q == '0));
  // R4
  abort_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && reg_wdata[1:0] == 2'd2) |=> scsi_cancel);
  // R4
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && reg_wdata[1:0] == 2'd2 && !scsi_cmd_done) |=> $stable(wbc_q) && $stable(wac_q));
  // R5
  beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ok |=> wbc_q == $past(wbc_q) - $past(moved_cnt));
  // R6
  beat_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && moved_cnt == wbc_q) |=> dma_done);
  // R7
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && reject) |=> $stable(wbc_q) && $stable(wac_q));
  // R5
  moved_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (COUNT_W'(xfer_moved) <= wbc_q) && (xfer_moved <= xfer_len));
  // R11
  cmplt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scsi_cmd_done && !start_p) |=> (wbc_q == '0) && dma_done);
endmodule

// File: tb/tb_hdma_channel.sv
module tb_hdma_channel;
  localparam int CW = 8, AW = 16, LW = 4, RAW = 4;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic          reg_wr_en = 0, reg_rd_en = 0;
  logic [RAW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic          scsi_irq = 0, scsi_cmd_done = 0;
  logic          xfer_valid = 0, xfer_ready, xfer_to_mem = 0, xfer_reject;
  logic [LW-1:0] xfer_len = '0, xfer_moved;
  logic          dma_req_en, scsi_cancel, dma_done;

  hdma_channel #(.COUNT_W(CW), .ADDR_W(AW), .LEN_W(LW), .RAW(RAW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scsi_irq(scsi_irq), .scsi_cmd_done(scsi_cmd_done),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_to_mem(xfer_to_mem),
    .xfer_len(xfer_len), .xfer_moved(xfer_moved), .xfer_reject(xfer_reject),
    .dma_req_en(dma_req_en), .scsi_cancel(scsi_cancel), .dma_done(dma_done)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = RAW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = RAW'(a);
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd_en = 0;
  endtask

  task automatic beat(input logic dir, input int len, output int m, output logic rj);
    @(negedge clk);
    xfer_valid = 1; xfer_to_mem = dir; xfer_len = LW'(len);
    #1 m = int'(xfer_moved); rj = xfer_reject;
    @(negedge clk);
    xfer_valid = 0;
  endtask

  task automatic run_start(input int cnt, input int adr, input logic [7:0] cmd);
    wr(1, 32'(cnt));
    wr(2, 32'(adr));
    wr(0, {24'h0, cmd});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int m, exp_m;
    logic rj;

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(0, v); chk("R1 cmd", v, 0);
    rd(4, v); chk("R1 wcnt", v, 0);
    rd(5, v); chk("R1 wadr", v, 32'hFFFF);
    rd(7, v); chk("R1 wdsc", v, 32'hFFFD);
    rd(6, v); chk("R1 stat", v, 0);
    rd(8, v); chk("R1 bctl", v, 0);
    chk("R1 outs", {dma_req_en, scsi_cancel, dma_done}, 0);
    // R13 unused index
    rd(12, v); chk("R13 unused", v, 0);

    // R2 command storage and ops
    wr(0, 32'hA5); rd(0, v); chk("R2 readback", v, 32'hA5);
    chk("R2 blast no enable", dma_req_en, 0);
    wr(0, 32'h83); chk("R2 start enables", dma_req_en, 1);
    wr(0, 32'h81); chk("R2 blast keeps", dma_req_en, 1);
    wr(0, 32'h80); chk("R2 idle drops", dma_req_en, 0);

    // R5 R6 sweep of count against length
    for (int c = 0; c < 32; c++) begin
      for (int l = 0; l < 16; l++) begin
        int a;
        a = (c * 37 + l * 11) & 16'hFFFF;
        run_start(c, a, 8'h83);
        beat(1'b1, l, m, rj);
        exp_m = (l < c) ? l : c;
        chk("R5 moved", 32'(m), 32'(exp_m));
        rd(4, v); chk("R5 wcnt", v, 32'(c - exp_m));
        rd(5, v); chk("R5 wadr", v, 32'((a + exp_m) & 16'hFFFF));
        chk("R6 done", dma_done, (c - exp_m) == 0);
      end
    end

    // R6 multi-beat run to zero
    run_start(9, 16'h0100, 8'h83);
    beat(1'b1, 4, m, rj); chk("R6 not yet", dma_done, 0);
    beat(1'b1, 4, m, rj); chk("R6 not yet 2", dma_done, 0);
    beat(1'b1, 4, m, rj); chk("R6 tail moved", 32'(m), 1);
    chk("R6 done at zero", dma_done, 1);
    rd(5, v); chk("R6 wadr", v, 32'h0109);

    // R3 start copies and clears status
    wr(3, 32'h1234);
    run_start(7, 16'h0BEE, 8'h83);
    rd(4, v); chk("R3 wcnt", v, 7);
    rd(5, v); chk("R3 wadr", v, 32'h0BEE);
    rd(7, v); chk("R3 wdsc", v, 32'h1234);
    chk("R3 status cleared", dma_done, 0);

    // R7 direction mismatch
    run_start(10, 16'h0200, 8'h03);
    beat(1'b1, 4, m, rj);
    chk("R7 reject", rj, 1); chk("R7 moved", 32'(m), 0);
    rd(4, v); chk("R7 wcnt", v, 10);
    rd(5, v); chk("R7 wadr", v, 32'h0200);
    beat(1'b0, 4, m, rj);
    chk("R7 accept", rj, 0); chk("R7 moved ok", 32'(m), 4);

    // R8 merged interrupt bit
    scsi_irq = 1; rd(6, v); chk("R8 irq shown", v[4], 1);
    scsi_irq = 0; rd(6, v); chk("R8 not stored", v[4], 0);

    // R9 clear on read (bctl bit24 = 0)
    run_start(2, 0, 8'h83); beat(1'b1, 5, m, rj);
    wr(6, 32'hFF);
    rd(6, v); chk("R9 write ignored", v, 32'h08);
    rd(6, v); chk("R9 read cleared", v, 32'h00);

    // R10 clear on write (bctl bit24 = 1)
    wr(8, 32'h0100_0000);
    rd(8, v); chk("R10 bctl", v, 32'h0100_0000);
    run_start(2, 0, 8'h83); beat(1'b1, 5, m, rj);
    rd(6, v); chk("R10 read", v, 32'h08);
    rd(6, v); chk("R10 read no clear", v, 32'h08);
    wr(6, 32'h04); rd(6, v); chk("R10 other bit", v, 32'h08);
    wr(6, 32'h08); rd(6, v); chk("R10 write clear", v, 32'h00);
    wr(8, 32'h0);

    // R11 completion
    run_start(20, 0, 8'h83);
    @(negedge clk); scsi_cmd_done = 1;
    @(negedge clk); scsi_cmd_done = 0;
    rd(4, v); chk("R11 wcnt", v, 0);
    chk("R11 done", dma_done, 1);

    // R12 back-pressure
    run_start(50, 16'h0300, 8'h83);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 0; reg_wdata = 32'h81;
    xfer_valid = 1; xfer_to_mem = 1; xfer_len = 5;
    #1 chk("R12 ready low on cmd write", xfer_ready, 0);
    @(negedge clk); reg_wr_en = 0; xfer_valid = 0;
    rd(4, v); chk("R12 no beat", v, 50);
    @(negedge clk);
    scsi_cmd_done = 1; xfer_valid = 1;
    #1 chk("R12 ready low on cmplt", xfer_ready, 0);
    @(negedge clk); scsi_cmd_done = 0; xfer_valid = 0;
    rd(5, v); chk("R12 wadr kept", v, 32'h0300);

    // R4 abort
    run_start(30, 16'h0400, 8'h83);
    wr(0, 32'h82);
    chk("R4 cancel high", scsi_cancel, 1);
    @(negedge clk);
    chk("R4 cancel low", scsi_cancel, 0);
    rd(4, v); chk("R4 wcnt", v, 30);
    rd(5, v); chk("R4 wadr", v, 32'h0400);
    chk("R4 enable kept", dma_req_en, 1);

    // R13 read-only writes ignored
    wr(4, 32'h11); wr(5, 32'h22); wr(7, 32'h33);
    rd(4, v); chk("R13 wcnt ro", v, 30);
    rd(5, v); chk("R13 wadr ro", v, 32'h0400);
    rd(7, v); chk("R13 wdsc ro", v, 32'h1234);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule